// File: doc/BRIEF.md
# Locked Test-and-Set Sequencer

This block carries out the byte test-and-set instruction for a core with a 16-bit data bus. It recognises the opcode, forms the effective address for every alterable data addressing mode, and then runs one indivisible read-modify-write on the memory bus. The condition codes come from the byte as it was read, and the byte goes back to memory with its top bit set. Software uses this to claim a semaphore that several bus masters share.

The core pulses `start` with the opcode and the current program counter. The block reads registers through a select/data pair, requests register updates with write pulses, and fetches extension words and the closing prefetch word itself. While the locked access runs, the address strobe stays asserted from the read, through the modify time, to the end of the write. An external master's bus request is therefore only granted while the sequencer is idle.

Top module: `tas_seq`

## Requirements
- R1: The instruction is accepted only when `opcode & 0xFFC0 == 0x4AC0`. Opcode bits 5:3 hold the mode and bits 2:0 the register. Any other opcode raises `illegal` for one cycle, leaves `busy` low and starts no bus cycle.
- R2: Address-register direct (mode 1) and mode 7 with register 2 to 7 raise `illegal` for one cycle. They start no bus cycle.
- R3: `flags` is {N,Z,V,C}. N takes bit 7 of the byte that was read, and Z is 1 when that byte is zero. V and C are always cleared.
- R4: Memory receives the read byte ORed with 0x80, on the lane picked by address bit 0 (0 = upper lane, D15:8). The other byte of the word is left unchanged.
- R5: For a data-register destination (mode 0), bits 31:8 of the register are kept and the low byte gets bit 7 set. No operand access takes place. A single prefetch follows, and `done` is high 2 cycles after `start`.
- R6: The address strobe stays high, with the address unchanged, from the operand read through the end of the write. `ext_gnt` is never high while the strobe is high. `ext_gnt` goes high only when the block is idle and `start` is low.
- R7: After the read data is latched, the block spends 9 cycles with the strobe held, read/write low, write data driven and both byte selects off. The byte-select write phase that follows lasts 3 cycles.
- R8: Postincrement (mode 3) writes An+1 back after the access. Predecrement (mode 4) writes An-1 back, uses it as the operand address and adds one idle cycle before the read.
- R9: Modes 5, 6 and 7/0 fetch one extension word and mode 7/1 fetches two (high word first); `next_pc` ends 2 bytes past each fetched word plus the prefetch. Measured from the start edge to `done`: 2 cycles for mode 0, 16 for modes 2 and 3, 17 for mode 4, 18 for modes 5, 6 and 7/0, and 19 for 7/1. The indexed extension word reads as follows: bit 15 set selects An, clear selects Dn. Bits 14:12 give the index register. Bit 11 set uses the full 32 bits, clear uses the sign-extended low word. Bits 7:0 are a signed displacement.
- R10: `done` is high for one cycle, in the cycle right after the last strobe of the sequence drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin executing `opcode` |
| opcode | input | 16 | Instruction word |
| pc_in | input | 32 | Address of the first extension word |
| reg_sel | output | 3 | Register number for `d_rd`, `a_rd` and the write pulses |
| d_rd | input | 32 | Selected data register |
| a_rd | input | 32 | Selected address register |
| idx_sel | output | 4 | Index register select (bit 3: 1 = address) |
| idx_rd | input | 32 | Selected index register |
| d_we | output | 1 | Write pulse for data register `reg_sel` |
| d_wd | output | 32 | Data register write value |
| a_we | output | 1 | Write pulse for address register `reg_sel` |
| a_wd | output | 32 | Address register write value |
| flags | output | 4 | {N,Z,V,C} |
| next_pc | output | 32 | Program counter after the fetches |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle rejection pulse |
| ext_req | input | 1 | Bus request from another master |
| ext_gnt | output | 1 | Bus grant to that master |
| bus_addr | output | 32 | Byte address |
| bus_as | output | 1 | Address strobe |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_uds | output | 1 | Upper byte select (D15:8) |
| bus_lds | output | 1 | Lower byte select (D7:0) |
| bus_dout | output | 16 | Write data |
| bus_din | input | 16 | Read data |
| bus_dtack | input | 1 | Transfer acknowledge |

## Verification
Every result has a fixed due time. Flags, register pulses and memory bytes are final by the `done` cycle. `done` itself is due 2, 16, 17, 18 or 19 edges after the start edge, depending on the mode, with a zero-wait memory. The bench counts edges from the start edge until it sees `done`, sampling half a period after each edge, and compares that count with the figure for the mode. Only after that does it read memory, registers, `flags` and `next_pc`. A monitor running at every falling edge measures the strobe run on the operand address (13), the strobe-held write-without-select cycles (9) and the write-select cycles (3). The same monitor fails any cycle in which the grant and the strobe are high together. Illegal opcodes are checked one edge after `start`.

// File: rtl/tas_seq.sv
module tas_seq #(
  parameter int HOLD_CYC = 9,
  parameter int WR_CYC   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] opcode,
  input  logic [31:0] pc_in,
  output logic [2:0]  reg_sel,
  input  logic [31:0] d_rd,
  input  logic [31:0] a_rd,
  output logic [3:0]  idx_sel,
  input  logic [31:0] idx_rd,
  output logic        d_we,
  output logic [31:0] d_wd,
  output logic        a_we,
  output logic [31:0] a_wd,
  output logic [3:0]  flags,
  output logic [31:0] next_pc,
  output logic        busy,
  output logic        done,
  output logic        illegal,
  input  logic        ext_req,
  output logic        ext_gnt,
  output logic [31:0] bus_addr,
  output logic        bus_as,
  output logic        bus_rw,
  output logic        bus_uds,
  output logic        bus_lds,
  output logic [15:0] bus_dout,
  input  logic [15:0] bus_din,
  input  logic        bus_dtack
);
  localparam int CW = $clog2(HOLD_CYC + WR_CYC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_EXT, S_ADDR, S_PRE, S_LRD, S_HOLD, S_LWR, S_GAP, S_PF, S_DONE
  } st_t;

  st_t         st;
  logic [5:0]  op_q;
  logic [31:0] pc_q, base_q, ea_q;
  logic [15:0] ext_q, ext_hi;
  logic [1:0]  ext_left;
  logic [7:0]  rd_q;
  logic [CW-1:0] cnt;
  logic [31:0] ea_calc, idx_val;

  wire [2:0] m_in = opcode[5:3];
  wire [2:0] r_in = opcode[2:0];
  wire hit     = (opcode & 16'hFFC0) == 16'h4AC0;
  wire mode_ok = (m_in == 3'd0) || (m_in >= 3'd2 && m_in <= 3'd6) ||
                 (m_in == 3'd7 && r_in <= 3'd1);
  wire [2:0] m_q = op_q[5:3];
  wire [7:0] rd_byte = ea_q[0] ? bus_din[7:0] : bus_din[15:8];
  wire [7:0] wb_byte = rd_q | 8'h80;

  wire is_word = (st == S_EXT) || (st == S_PF);
  wire is_byte = (st == S_LRD) || (st == S_LWR);
  wire is_wr   = (st == S_HOLD) || (st == S_LWR);

  assign reg_sel  = (st == S_IDLE) ? r_in : op_q[2:0];
  assign idx_sel  = ext_q[15:12];
  assign busy     = st != S_IDLE;
  assign done     = st == S_DONE;
  assign ext_gnt  = ext_req && (st == S_IDLE) && !start;
  assign next_pc  = pc_q;
  assign bus_as   = is_word || is_byte || (st == S_HOLD);
  assign bus_rw   = !is_wr;
  assign bus_uds  = is_word || (is_byte && !ea_q[0]);
  assign bus_lds  = is_word || (is_byte && ea_q[0]);
  assign bus_addr = is_word ? pc_q : ea_q;
  assign bus_dout = is_wr ? {wb_byte, wb_byte} : 16'h0000;

  assign idx_val = ext_q[11] ? idx_rd : {{16{idx_rd[15]}}, idx_rd[15:0]};

  always_comb begin
    case (m_q)
      3'd5:    ea_calc = base_q + {{16{ext_q[15]}}, ext_q};
      3'd6:    ea_calc = base_q + {{24{ext_q[7]}}, ext_q[7:0]} + idx_val;
      default: ea_calc = op_q[0] ? {ext_hi, ext_q} : {{16{ext_q[15]}}, ext_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_q     <= '0;
      pc_q     <= '0;
      base_q   <= '0;
      ea_q     <= '0;
      ext_q    <= '0;
      ext_hi   <= '0;
      ext_left <= '0;
      rd_q     <= '0;
      cnt      <= '0;
      flags    <= '0;
      d_we     <= 1'b0;
      d_wd     <= '0;
      a_we     <= 1'b0;
      a_wd     <= '0;
      illegal  <= 1'b0;
    end else begin
      d_we    <= 1'b0;
      a_we    <= 1'b0;
      illegal <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (!(hit && mode_ok)) begin
            illegal <= 1'b1;
          end else begin
            op_q   <= opcode[5:0];
            pc_q   <= pc_in;
            base_q <= a_rd;
            case (m_in)
              3'd0: begin
                flags <= {d_rd[7], d_rd[7:0] == 8'h00, 2'b00};
                d_wd  <= {d_rd[31:8], d_rd[7:0] | 8'h80};
                d_we  <= 1'b1;
                st    <= S_PF;
              end
              3'd2, 3'd3: begin
                ea_q <= a_rd;
                st   <= S_LRD;
              end
              3'd4: begin
                ea_q <= a_rd - 32'd1;
                a_wd <= a_rd - 32'd1;
                a_we <= 1'b1;
                st   <= S_PRE;
              end
              default: begin
                ext_left <= (m_in == 3'd7 && r_in == 3'd1) ? 2'd2 : 2'd1;
                st       <= S_EXT;
              end
            endcase
          end
        end
        S_EXT: if (bus_dtack) begin
          ext_hi   <= ext_q;
          ext_q    <= bus_din;
          pc_q     <= pc_q + 32'd2;
          ext_left <= ext_left - 2'd1;
          if (ext_left == 2'd1) st <= S_ADDR;
        end
        S_ADDR: begin
          ea_q <= ea_calc;
          st   <= S_LRD;
        end
        S_PRE: st <= S_LRD;
        S_LRD: if (bus_dtack) begin
          rd_q  <= rd_byte;
          flags <= {rd_byte[7], rd_byte == 8'h00, 2'b00};
          cnt   <= '0;
          st    <= S_HOLD;
        end
        S_HOLD: begin
          if (cnt == CW'(HOLD_CYC - 1)) begin
            cnt <= '0;
            st  <= S_LWR;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_LWR: begin
          if (cnt == CW'(WR_CYC - 1)) begin
            cnt <= '0;
            st  <= S_GAP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_GAP: begin
          if (m_q == 3'd3) begin
            a_wd <= base_q + 32'd1;
            a_we <= 1'b1;
          end
          st <= S_PF;
        end
        S_PF: if (bus_dtack) begin
          pc_q <= pc_q + 32'd2;
          st   <= S_DONE;
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tas_seq_chk.sv
module tas_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ext_gnt,
  input logic        bus_as,
  input logic        bus_rw,
  input logic        bus_uds,
  input logic        bus_lds,
  input logic [31:0] bus_addr,
  input logic [15:0] bus_dout,
  input logic        illegal,
  input logic        busy,
  input logic        done
);
  AST_NO_GRANT_UNDER_AS: assert property (@(posedge clk) disable iff (!rst_n)
    ext_gnt |-> !bus_as); // R6
  AST_ADDR_HELD_IN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && !bus_rw && $past(bus_as)) |-> (bus_addr == $past(bus_addr))); // R6
  AST_WRITE_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rw && (bus_uds || bus_lds)) |-> (bus_dout[15] && bus_dout[7])); // R4
  AST_WRITE_INSIDE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rw |-> bus_as); // R7
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!busy && !bus_as)); // R2
  AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_as && $past(bus_as))); // R10
endmodule

bind tas_seq tas_seq_chk u_chk (.*);

// File: tb/tas_seq_test.sv
`timescale 1ns/100ps
module tas_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start = 1'b0;
  logic [15:0] opcode = '0;
  logic [31:0] pc_in = '0;
  logic [2:0]  reg_sel;
  logic [31:0] d_rd, a_rd, idx_rd, d_wd, a_wd, next_pc, bus_addr;
  logic [3:0]  idx_sel, flags;
  logic        d_we, a_we, busy, done, illegal, ext_gnt;
  logic        ext_req = 1'b0;
  logic        bus_as, bus_rw, bus_uds, bus_lds, bus_dtack;
  logic [15:0] bus_dout, bus_din;

  tas_seq uut (.*);

  logic [7:0]  mem [0:255];
  logic [31:0] dreg [0:7];
  logic [31:0] areg [0:7];

  assign d_rd      = dreg[reg_sel];
  assign a_rd      = areg[reg_sel];
  assign idx_rd    = idx_sel[3] ? areg[idx_sel[2:0]] : dreg[idx_sel[2:0]];
  assign bus_din   = {mem[{bus_addr[7:1], 1'b0}], mem[{bus_addr[7:1], 1'b1}]};
  assign bus_dtack = bus_as && (bus_uds || bus_lds);

  always @(posedge clk) begin
    if (bus_as && !bus_rw) begin
      if (bus_uds) mem[{bus_addr[7:1], 1'b0}] <= bus_dout[15:8];
      if (bus_lds) mem[{bus_addr[7:1], 1'b1}] <= bus_dout[7:0];
    end
    if (d_we) dreg[reg_sel] <= d_wd;
    if (a_we) areg[reg_sel] <= a_wd;
  end

  int checks = 0, errors = 0;
  int run_cur = 0, run_max = 0, nostrb = 0, wr_cnt = 0;
  logic [31:0] ea_exp = '0;
  bit finished = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ext_gnt && bus_as) begin
        checks++; errors++;
        $display("FAIL R6 grant with strobe: gnt=%0d as=%0d expected gnt=0", ext_gnt, bus_as);
      end
      if (bus_as && bus_addr == ea_exp) begin
        run_cur++;
        if (run_cur > run_max) run_max = run_cur;
      end else run_cur = 0;
      if (bus_as && !bus_rw && !bus_uds && !bus_lds) nostrb++;
      if (bus_as && !bus_rw && (bus_uds || bus_lds)) wr_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] op, input logic [31:0] pc, output int lat);
    @(negedge clk); #1;
    run_cur = 0; run_max = 0; nostrb = 0; wr_cnt = 0;
    opcode = op; pc_in = pc; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    lat = 1;
    while (!done && lat < 60) begin
      @(negedge clk); #1;
      lat++;
    end
    @(negedge clk); #1;
  endtask

  function automatic logic [3:0] fexp(input logic [7:0] v);
    return {v[7], v == 8'h00, 2'b00};
  endfunction

  task automatic t_dn(input logic [7:0] v);
    int lat;
    dreg[3] = {24'hABCD12, v};
    ea_exp = 32'hFFFF_FFFF;
    run_op(16'h4AC3, 32'h40, lat);
    chk("R5 latency", lat, 2);
    chk("R5 register", dreg[3], {24'hABCD12, v | 8'h80});
    chk("R3 flags dn", {28'h0, flags}, {28'h0, fexp(v)});
    chk("R5 no operand write", wr_cnt, 0);
    chk("R9 next_pc dn", next_pc, 32'h42);
  endtask

  task automatic t_ind(input logic [7:0] v, input bit odd);
    int lat;
    logic [7:0] other;
    logic [31:0] adr;
    adr = odd ? 32'h91 : 32'h90;
    areg[1] = adr;
    mem[8'h90] = odd ? 8'h5A : v;
    mem[8'h91] = odd ? v : 8'h5A;
    ea_exp = adr;
    run_op(16'h4AD1, 32'h40, lat);
    chk("R9 latency (An)", lat, 16);
    chk("R4 written byte", mem[adr[7:0]], v | 8'h80);
    other = mem[adr[7:0] ^ 8'h01];
    chk("R4 other lane", other, 8'h5A);
    chk("R3 flags mem", {28'h0, flags}, {28'h0, fexp(v)});
    chk("R6 strobe run at operand", run_max, 13);
    chk("R7 hold cycles", nostrb, 9);
    chk("R7 write select cycles", wr_cnt, 3);
    chk("R8 An unchanged (An)", areg[1], adr);
  endtask

  task automatic t_postinc;
    int lat;
    areg[2] = 32'h00A4; mem[8'hA4] = 8'h01; ea_exp = 32'hA4;
    run_op(16'h4ADA, 32'h40, lat);
    chk("R8 postinc latency", lat, 16);
    chk("R8 postinc An", areg[2], 32'hA5);
    chk("R4 postinc mem", mem[8'hA4], 8'h81);
  endtask

  task automatic t_predec;
    int lat;
    areg[4] = 32'h00B3; mem[8'hB2] = 8'h00; mem[8'hB3] = 8'h11; ea_exp = 32'hB2;
    run_op(16'h4AE4, 32'h40, lat);
    chk("R8 predec latency", lat, 17);
    chk("R8 predec An", areg[4], 32'hB2);
    chk("R8 predec mem", mem[8'hB2], 8'h80);
    chk("R8 predec neighbour", mem[8'hB3], 8'h11);
    chk("R3 predec flags", {28'h0, flags}, 32'h4);
  endtask

  task automatic t_d16;
    int lat;
    areg[5] = 32'h00D0; mem[8'h40] = 8'hFF; mem[8'h41] = 8'hF0;
    mem[8'hC0] = 8'h7F; ea_exp = 32'hC0;
    run_op(16'h4AED, 32'h40, lat);
    chk("R9 d16 latency", lat, 18);
    chk("R9 d16 target", mem[8'hC0], 8'hFF);
    chk("R9 d16 next_pc", next_pc, 32'h44);
  endtask

  task automatic t_idx;
    int lat;
    areg[2] = 32'h0080; dreg[5] = 32'h0001_0010;
    mem[8'h40] = 8'h50; mem[8'h41] = 8'h04;
    mem[8'h94] = 8'h33; ea_exp = 32'h94;
    run_op(16'h4AF2, 32'h40, lat);
    chk("R9 indexed latency", lat, 18);
    chk("R9 indexed target", mem[8'h94], 8'hB3);
  endtask

  task automatic t_abs;
    int lat;
    mem[8'h40] = 8'h00; mem[8'h41] = 8'hA0; mem[8'hA0] = 8'h80; ea_exp = 32'hA0;
    run_op(16'h4AF8, 32'h40, lat);
    chk("R9 abs short latency", lat, 18);
    chk("R9 abs short target", mem[8'hA0], 8'h80);
    chk("R3 abs short flags", {28'h0, flags}, 32'h8);
    mem[8'h40] = 8'h00; mem[8'h41] = 8'h00; mem[8'h42] = 8'h00; mem[8'h43] = 8'hA3;
    mem[8'hA3] = 8'h02; ea_exp = 32'hA3;
    run_op(16'h4AF9, 32'h40, lat);
    chk("R9 abs long latency", lat, 19);
    chk("R9 abs long target", mem[8'hA3], 8'h82);
    chk("R9 abs long next_pc", next_pc, 32'h46);
  endtask

  task automatic t_illegal(input logic [15:0] op, input string req);
    @(negedge clk); #1;
    opcode = op; start = 1'b1; run_cur = 0; wr_cnt = 0;
    @(negedge clk); #1;
    start = 1'b0;
    chk(req, {29'h0, illegal, busy, bus_as}, 32'h4);
    @(negedge clk); #1;
    chk(req, {30'h0, busy, bus_as}, 32'h0);
  endtask

  task automatic t_grant;
    int lat;
    areg[1] = 32'h90; mem[8'h90] = 8'h10; ea_exp = 32'h90;
    ext_req = 1'b1;
    run_op(16'h4AD1, 32'h40, lat);
    chk("R6 grant after release", ext_gnt, 1'b1);
    ext_req = 1'b0;
    chk("R10 done latency with request", lat, 16);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < 8; i++) begin dreg[i] = '0; areg[i] = '0; end
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset done", {29'h0, done, busy, bus_as}, 32'h0);
    chk("R3 reset flags", {28'h0, flags}, 32'h0);
    rst_n = 1'b1;
    t_dn(8'h00); t_dn(8'h7F); t_dn(8'h80); t_dn(8'hFF);
    t_ind(8'h00, 0); t_ind(8'h7F, 1); t_ind(8'h80, 0); t_ind(8'hFF, 1);
    t_postinc;
    t_predec;
    t_d16;
    t_idx;
    t_abs;
    t_illegal(16'h4A40, "R1 non-matching opcode");
    t_illegal(16'h4AC9, "R2 address register direct");
    t_illegal(16'h4AFC, "R2 mode 7 register 4");
    t_grant;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule